// File: doc/BRIEF.md
# Pipeline Slot Fraction Metrics Unit

The unit tracks how the issue slots of a pipeline were spent across four categories: retiring, bad speculation, frontend bound and backend bound. Each category has a hidden event counter that software cannot preload. Next to them runs a visible slots counter, which software can read and load. When software asks for the metrics word, the unit turns each hidden count into an 8-bit fraction of the slots counter's value at that moment. The fraction is 255 times the count divided by slots. The four fractions are packed into one 32-bit word. A sticky flag reports that any hidden counter has wrapped. A metrics clear strobe zeroes the hidden counters and the flag together.

A read is a request/response exchange. The request side is a valid/ready pair, and `rd_ready` is high only while the unit is idle. The request is accepted on a clock edge where `rd_valid` and `rd_ready` are both high. The response side is also a valid/ready pair. Once `mx_valid` rises, `mx_data` holds steady until the consumer raises `mx_ready`, so the consumer may hold back the response for any number of cycles. No new request is accepted until the response has been taken. The increment strobes, the slots load and the clear strobe are plain level inputs, sampled on every rising edge.

Top module: `slot_mix_meter`

## Requirements
- R1: A returned field equals floor(255 × category count / slots), where the count and slots are the values at the accepting clock edge. For example, a count of 10 against slots of 100 reads 25.
- R2: The fields are packed with retiring in bits 7:0, bad speculation in bits 15:8, frontend bound in bits 23:16 and backend bound in bits 31:24.
- R3: When slots is zero at request acceptance, every field reads 0, whatever the category counts are.
- R4: A quotient above 255 reads as 255 (0xFF).
- R5: Increments, slots loads and clears that arrive after the request is accepted do not change the word returned for that request.
- R6: After `mx_valid` rises, it stays high and `mx_data` stays stable until a cycle with `mx_ready` high. `rd_ready` is low from request acceptance until the response is taken, and `rd_ready` and `mx_valid` are never high together.
- R7: `metrics_clr` zeroes all four category counters and clears `metrics_ovf` on the next edge. It wins over a simultaneous increment, and it leaves `slots_count` unchanged.
- R8: `metrics_ovf` is set on the edge where any category counter wraps. It then stays set until `metrics_clr`.
- R9: A category counter wraps from all ones to zero, modulo 2^CNT_W.
- R10: `slots_count` goes up by one for each cycle with `inc_slots` high. `slots_wr_en` loads `slots_wr_data` instead, and the load wins over a simultaneous increment.
- R11: After reset, all counters are zero, `metrics_ovf` is 0, `mx_valid` is 0 and `rd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_retire | input | 1 | Retiring slot event this cycle |
| inc_badspec | input | 1 | Bad speculation slot event this cycle |
| inc_front | input | 1 | Frontend bound slot event this cycle |
| inc_back | input | 1 | Backend bound slot event this cycle |
| inc_slots | input | 1 | Slots counter increment |
| slots_wr_en | input | 1 | Load the slots counter |
| slots_wr_data | input | SLOT_W | Value loaded into the slots counter |
| metrics_clr | input | 1 | Clear the category counters and the overflow flag |
| rd_valid | input | 1 | Metrics read request |
| rd_ready | output | 1 | Unit idle, so a request can be accepted |
| mx_valid | output | 1 | Metrics word available |
| mx_ready | input | 1 | Consumer takes the metrics word |
| mx_data | output | 32 | Packed fractions |
| slots_count | output | SLOT_W | Visible slots counter |
| metrics_ovf | output | 1 | Sticky wrap flag |

## Verification
The bench goes after the cases where the division itself can break. With slots zero, a design that divides anyway returns garbage or all ones instead of zeros. A count above slots must read 0xFF, where a truncated quotient would wrap to a small value. Increments and slots loads are fired while the division is running. A design without a snapshot would then return fields from mixed moments. Overflow is checked at the exact wrap cycle, and again after further counting and after a clear. This catches a flag that fires one cycle late, one that is not sticky, and a clear that also wipes the slots counter. The response is held back for several cycles to expose data that changes while it waits.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int NCAT   = 4;
  localparam int FRAC_W = 8;
  localparam int WORD_W = NCAT * FRAC_W;

  typedef enum logic [1:0] {
    CAT_RET = 2'd0,
    CAT_BAD = 2'd1,
    CAT_FE  = 2'd2,
    CAT_BE  = 2'd3
  } cat_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CALC = 2'd1,
    SQ_HOLD = 2'd2
  } seq_e;
endpackage

// File: rtl/slot_cnt_bank.sv
module slot_cnt_bank
  import sfm_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int SLOT_W = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic [NCAT-1:0]            inc,
  input  logic                       slots_inc,
  input  logic                       slots_ld,
  input  logic [SLOT_W-1:0]          slots_ld_val,
  output logic [NCAT-1:0][CNT_W-1:0] cnt,
  output logic [SLOT_W-1:0]          slots,
  output logic                       ovf
);
  logic [NCAT-1:0] wrap;

  for (genvar g = 0; g < NCAT; g++) begin : g_cat
    assign wrap[g] = inc[g] & (&cnt[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)       cnt[g] <= '0;
      else if (clr)     cnt[g] <= '0;
      else if (inc[g])  cnt[g] <= cnt[g] + CNT_W'(1);
    end

    // R9: a counter at all ones steps to zero and raises the flag
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (inc[g] && !clr && (&cnt[g])) |=> (cnt[g] == '0) && ovf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf <= 1'b0;
    else if (clr)     ovf <= 1'b0;
    else if (|wrap)   ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          slots <= '0;
    else if (slots_ld)   slots <= slots_ld_val;
    else if (slots_inc)  slots <= slots + SLOT_W'(1);
  end

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0) && !ovf);
  a_r7_slots_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !slots_ld && !slots_inc) |=> $stable(slots));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    slots_ld |=> slots == $past(slots_ld_val));
  a_r10_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!slots_ld && slots_inc) |=> slots == $past(slots) + SLOT_W'(1));
endmodule

// File: rtl/frac_div.sv
module frac_div
  import sfm_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int SLOT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  num,
  input  logic [SLOT_W-1:0] den,
  output logic              done,
  output logic [FRAC_W-1:0] q
);
  localparam int NUM_W = CNT_W + FRAC_W;
  localparam int DEN_W = SLOT_W + FRAC_W;
  localparam int WW    = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 1;
  localparam int BI_W  = $clog2(FRAC_W);
  localparam logic [BI_W-1:0] TOP_BIT = BI_W'(FRAC_W - 1);

  logic [WW-1:0]   scaled, den_top;
  logic [WW-1:0]   rem, dsh;
  logic [BI_W-1:0] bit_i;
  logic            busy;

  // 255 * num without a multiplier
  assign scaled  = (WW'(num) << FRAC_W) - WW'(num);
  assign den_top = WW'(den) << FRAC_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      dsh   <= '0;
      bit_i <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      q     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (den == '0) begin
          q    <= '0;
          done <= 1'b1;
        end else if (scaled >= den_top) begin
          q    <= '1;
          done <= 1'b1;
        end else begin
          rem   <= scaled;
          dsh   <= WW'(den) << TOP_BIT;
          bit_i <= TOP_BIT;
          q     <= '0;
          busy  <= 1'b1;
        end
      end else if (busy) begin
        if (rem >= dsh) begin
          rem      <= rem - dsh;
          q[bit_i] <= 1'b1;
        end
        dsh <= dsh >> 1;
        if (bit_i == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_i <= bit_i - BI_W'(1);
        end
      end
    end
  end

  a_r3_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
    (start && den == '0) |=> done && (q == '0));
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (start && den != '0 && scaled >= den_top) |=> done && (q == '1));
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_i == '0) |=> done);
endmodule

// File: rtl/slot_mix_meter.sv
module slot_mix_meter
  import sfm_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int SLOT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_retire,
  input  logic              inc_badspec,
  input  logic              inc_front,
  input  logic              inc_back,
  input  logic              inc_slots,
  input  logic              slots_wr_en,
  input  logic [SLOT_W-1:0] slots_wr_data,
  input  logic              metrics_clr,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              mx_valid,
  input  logic              mx_ready,
  output logic [31:0]       mx_data,
  output logic [SLOT_W-1:0] slots_count,
  output logic              metrics_ovf
);
  localparam int IDX_W = $clog2(NCAT);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCAT - 1);

  logic [NCAT-1:0]              inc_vec;
  logic [NCAT-1:0][CNT_W-1:0]   cnt;
  logic [NCAT-1:0][CNT_W-1:0]   snap_cnt;
  logic [SLOT_W-1:0]            snap_slots;
  logic [NCAT-1:0][FRAC_W-1:0]  fields;
  logic [IDX_W-1:0]             idx;
  logic                         start, done;
  logic [FRAC_W-1:0]            q;
  seq_e                         state;

  assign inc_vec[CAT_RET] = inc_retire;
  assign inc_vec[CAT_BAD] = inc_badspec;
  assign inc_vec[CAT_FE]  = inc_front;
  assign inc_vec[CAT_BE]  = inc_back;

  slot_cnt_bank #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (metrics_clr),
    .inc          (inc_vec),
    .slots_inc    (inc_slots),
    .slots_ld     (slots_wr_en),
    .slots_ld_val (slots_wr_data),
    .cnt          (cnt),
    .slots        (slots_count),
    .ovf          (metrics_ovf)
  );

  frac_div #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .num   (snap_cnt[idx]),
    .den   (snap_slots),
    .done  (done),
    .q     (q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      idx        <= '0;
      start      <= 1'b0;
      snap_cnt   <= '0;
      snap_slots <= '0;
      fields     <= '0;
    end else begin
      start <= 1'b0;
      unique case (state)
        SQ_IDLE: if (rd_valid) begin
          snap_cnt   <= cnt;
          snap_slots <= slots_count;
          idx        <= '0;
          start      <= 1'b1;
          state      <= SQ_CALC;
        end
        SQ_CALC: if (done) begin
          fields[idx] <= q;
          if (idx == LAST_IDX) begin
            state <= SQ_HOLD;
          end else begin
            idx   <= idx + IDX_W'(1);
            start <= 1'b1;
          end
        end
        SQ_HOLD: if (mx_ready) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign rd_ready = (state == SQ_IDLE);
  assign mx_valid = (state == SQ_HOLD);
  assign mx_data  = fields;

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mx_valid && !mx_ready) |=> mx_valid && $stable(mx_data));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && mx_valid));
  a_r5_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready && !$rose(!rd_ready)) |-> $stable(snap_slots));
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> rd_ready && !mx_valid && !metrics_ovf);
endmodule

// File: tb/slot_mix_meter_tb_top.sv
module slot_mix_meter_tb_top;
  localparam int CW = 10;
  localparam int SW = 12;
  localparam int NV = 7;
  // ret, bad, fe, be, slots
  localparam int VEC [NV][5] = '{
    '{10, 20, 30, 40, 100},
    '{100, 50, 25, 5, 100},
    '{7, 3, 1, 0, 9},
    '{300, 1, 2, 3, 200},
    '{0, 0, 0, 0, 0},
    '{5, 9, 0, 1000, 0},
    '{1000, 999, 500, 1, 1000}
  };

  logic clk = 0, rst_n = 0;
  logic inc_retire = 0, inc_badspec = 0, inc_front = 0, inc_back = 0, inc_slots = 0;
  logic slots_wr_en = 0, metrics_clr = 0, rd_valid = 0, mx_ready = 0;
  logic [SW-1:0] slots_wr_data = '0;
  logic rd_ready, mx_valid, metrics_ovf;
  logic [31:0] mx_data;
  logic [SW-1:0] slots_count;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  slot_mix_meter #(.CNT_W(CW), .SLOT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_retire(inc_retire), .inc_badspec(inc_badspec),
    .inc_front(inc_front), .inc_back(inc_back), .inc_slots(inc_slots),
    .slots_wr_en(slots_wr_en), .slots_wr_data(slots_wr_data),
    .metrics_clr(metrics_clr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .mx_valid(mx_valid), .mx_ready(mx_ready), .mx_data(mx_data),
    .slots_count(slots_count), .metrics_ovf(metrics_ovf));

  function automatic logic [7:0] frac(input longint n, input longint s);
    longint v;
    if (s == 0) return 8'd0;
    v = (255 * n) / s;
    return (v > 255) ? 8'hFF : v[7:0];
  endfunction

  function automatic logic [31:0] pack(input longint r, input longint b,
                                       input longint f, input longint k, input longint s);
    return {frac(k, s), frac(f, s), frac(b, s), frac(r, s)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_metrics();
    @(negedge clk); metrics_clr = 1;
    @(negedge clk); metrics_clr = 0;
  endtask

  task automatic load_slots(input int v);
    @(negedge clk); slots_wr_en = 1; slots_wr_data = SW'(v);
    @(negedge clk); slots_wr_en = 0;
  endtask

  task automatic pump(input int r, input int b, input int f, input int k);
    int m;
    m = r; if (b > m) m = b; if (f > m) m = f; if (k > m) m = k;
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      inc_retire = (i < r); inc_badspec = (i < b); inc_front = (i < f); inc_back = (i < k);
    end
    @(negedge clk);
    inc_retire = 0; inc_badspec = 0; inc_front = 0; inc_back = 0;
  endtask

  task automatic wait_result(output logic [31:0] w);
    int n = 0;
    while (!mx_valid && n < 300) begin @(negedge clk); n++; end
    check("R6 response arrives", 64'(mx_valid), 64'd1);
    w = mx_data;
  endtask

  task automatic take_result(input logic [31:0] w);
    check("R6 rd_ready low while result held", 64'(rd_ready), 64'd0);
    repeat (3) @(negedge clk);
    check("R6 valid held under backpressure", 64'(mx_valid), 64'd1);
    check("R6 data stable under backpressure", 64'(mx_data), 64'(w));
    mx_ready = 1;
    @(negedge clk); mx_ready = 0;
    check("R6 valid drops after take", 64'(mx_valid), 64'd0);
    check("R6 idle after take", 64'(rd_ready), 64'd1);
  endtask

  task automatic do_read(output logic [31:0] w);
    @(negedge clk); rd_valid = 1;
    @(negedge clk); rd_valid = 0;
    wait_result(w);
    take_result(w);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 rd_ready", 64'(rd_ready), 64'd1);
    check("R11 mx_valid", 64'(mx_valid), 64'd0);
    check("R11 ovf", 64'(metrics_ovf), 64'd0);
    check("R11 slots", 64'(slots_count), 64'd0);
    do_read(w);
    check("R11 counters zero", 64'(w), 64'd0);

    // R1 R2 R3 R4 table walk
    for (int v = 0; v < NV; v++) begin
      clear_metrics();
      load_slots(VEC[v][4]);
      pump(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      do_read(w);
      check("R1 R2 R3 R4 word", 64'(w),
            64'(pack(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4])));
      check("R2 retiring field bits 7:0", 64'(w[7:0]), 64'(frac(VEC[v][0], VEC[v][4])));
      check("R2 backend field bits 31:24", 64'(w[31:24]), 64'(frac(VEC[v][3], VEC[v][4])));
    end

    // R5 snapshot at acceptance
    clear_metrics();
    load_slots(100);
    pump(10, 20, 30, 40);
    @(negedge clk); rd_valid = 1;
    @(negedge clk); rd_valid = 0;
    inc_retire = 1; inc_back = 1; slots_wr_en = 1; slots_wr_data = SW'(50);
    repeat (4) @(negedge clk);
    inc_retire = 0; inc_back = 0; slots_wr_en = 0;
    wait_result(w);
    check("R5 word frozen at acceptance", 64'(w), 64'(pack(10, 20, 30, 40, 100)));
    take_result(w);
    do_read(w);
    check("R5 next read sees new values", 64'(w), 64'(pack(14, 20, 30, 44, 50)));

    // R10 slots counter
    load_slots(5);
    @(negedge clk); inc_slots = 1;
    repeat (3) @(negedge clk);
    inc_slots = 0;
    check("R10 slots counts up", 64'(slots_count), 64'd8);
    @(negedge clk); inc_slots = 1; slots_wr_en = 1; slots_wr_data = SW'(77);
    @(negedge clk); inc_slots = 0; slots_wr_en = 0;
    check("R10 load wins over increment", 64'(slots_count), 64'd77);

    // R8 R9 wrap and sticky flag
    clear_metrics();
    load_slots(50);
    pump(0, 1023, 0, 0);
    check("R8 no flag before wrap", 64'(metrics_ovf), 64'd0);
    pump(0, 1, 0, 0);
    check("R8 flag set on wrap", 64'(metrics_ovf), 64'd1);
    do_read(w);
    check("R9 wrapped counter reads zero", 64'(w), 64'd0);
    pump(3, 3, 0, 0);
    check("R8 flag sticky", 64'(metrics_ovf), 64'd1);

    // R7 clear
    @(negedge clk); metrics_clr = 1; inc_retire = 1; inc_front = 1;
    @(negedge clk); metrics_clr = 0; inc_retire = 0; inc_front = 0;
    check("R7 flag cleared", 64'(metrics_ovf), 64'd0);
    check("R7 slots untouched", 64'(slots_count), 64'd50);
    do_read(w);
    check("R7 counters cleared over increment", 64'(w), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule